// File: doc/BRIEF.md
# Serial Port Data FIFO Front-End

This block is the data path between a 16-bit processor data register and the serial shift logic of a synchronous serial port. A register write places a word into a transmit queue. A register read removes the oldest word from a receive queue. The serial shifter side takes transmit words through a valid/ready handshake and hands in received frames with a valid strobe.

Frame length is programmed from 4 to 16 bits. The block trims transmit words to that length before presenting them to the shifter. It right-justifies received frames and fills the unused upper bits with zeros. In Microwire format only the low byte of a transmit word is sent, and the receive length still follows the programmed size.

Dropping the port enable empties both queues and keeps them empty. Occupancy counts and full/empty flags are exported for the status logic elsewhere. A write to a full transmit queue raises a one-cycle overflow pulse. A frame arriving at a full receive queue sets a sticky overrun flag.

Top module: `ssp_data_fifo`

## Requirements
- R1: With `port_en` high, a pulse on `wr_en` while the transmit queue is not full stores `wr_data`. Words leave in write order: `tx_data` shows the oldest stored word while `tx_valid` is high, and a cycle with `tx_valid` and `tx_ready` both high removes it.
- R2: `rd_data` shows the oldest receive entry in the same cycle (combinational). A cycle with `rd_en` high and the queue not empty removes that entry, and the next entry moves to the output.
- R3: When `microwire` is 0, `tx_data` equals the stored word with every bit at position N and above forced to 0. N is `data_size`+1. Codes 0, 1 and 2 act as code 3, which is 4 bits.
- R4: When `microwire` is 1, `tx_data` equals bits 7:0 of the stored word with bits 15:8 zero, whatever `data_size` holds.
- R5: A frame accepted on `rx_valid` is stored as `rx_data` bits N-1:0 with all higher bits zero. N is derived from `data_size` as in R3, in both formats.
- R6: `tx_level`/`rx_level` give the number of stored entries, from 0 to DEPTH (default 8). `*_full` is high exactly at DEPTH and `*_empty` is high exactly at 0. `tx_valid` equals not `tx_empty`.
- R7: A write while the transmit queue is full is dropped. `tx_overflow` is high during the single cycle after that write.
- R8: A read while the receive queue is empty returns 0 on `rd_data` and leaves the queue empty.
- R9: A frame arriving while the receive queue is full is discarded. `rx_overrun` becomes 1 in the next cycle and stays 1 while `port_en` remains high.
- R10: Reset, or any clock edge with `port_en` low, empties both queues and clears `rx_overrun` and `tx_overflow`. While `port_en` is low, writes and received frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low flushes and holds both queues empty |
| microwire | input | 1 | 1 selects Microwire format (8-bit transmit) |
| data_size | input | 4 | Frame length minus one (3..15; lower codes act as 3) |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 16 | Data register write value |
| rd_en | input | 1 | Data register read strobe |
| rd_data | output | 16 | Oldest receive entry, or 0 when empty |
| tx_valid | output | 1 | Transmit word available for the shifter |
| tx_ready | input | 1 | Shifter takes the transmit word |
| tx_data | output | 16 | Trimmed transmit word |
| rx_valid | input | 1 | Received frame strobe from the shifter |
| rx_data | input | 16 | Received frame, right-aligned |
| tx_level | output | $clog2(DEPTH+1) | Transmit queue occupancy |
| rx_level | output | $clog2(DEPTH+1) | Receive queue occupancy |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_overflow | output | 1 | One-cycle pulse after a dropped write |
| rx_overrun | output | 1 | Sticky flag for a discarded received frame |

## Verification
Random mixes of writes, reads, shifter pops and received frames run with random frame-size codes, including codes 0 to 2, in both formats. Each transmit word and received frame carries random upper bits, so wrong trimming or missing zero fill shows up as a data mismatch. Phases that starve the shifter or the reader drive each queue to full. This separates dropped writes and discarded frames from accepted ones, and it exercises the overflow pulse and the sticky overrun flag. Phases that read an empty queue and phases with the enable toggling test the zero read-back and the flush.

// File: rtl/ssp_fifo_pkg.sv
package ssp_fifo_pkg;
    localparam int WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [3:0]        size_code_t;

    // Low-bit mask for a frame-size code; codes below 3 act as a 4-bit frame.
    function automatic word_t size_mask(size_code_t code);
        word_t m;
        int    top_bit;
        top_bit = (code < 4'd3) ? 3 : int'(code);
        for (int i = 0; i < WORD_W; i++) begin
            m[i] = (i <= top_bit);
        end
        return m;
    endfunction
endpackage

// File: rtl/ssp_word_fifo.sv
module ssp_word_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH-1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     take_push, take_pop;

    always_comb begin
        st_d      = st_q;
        take_push = push && (st_q.cnt != FULL_CNT);
        take_pop  = pop && (st_q.cnt != '0);
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (take_push) begin
                st_d.mem[st_q.wp] = push_data;
                st_d.wp = (st_q.wp == LAST_IDX) ? '0 : st_q.wp + 1'b1;
            end
            if (take_pop) begin
                st_d.rp = (st_q.rp == LAST_IDX) ? '0 : st_q.rp + 1'b1;
            end
            if (take_push && !take_pop) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (!take_push && take_pop) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == FULL_CNT);
    assign empty = (st_q.cnt == '0);

    // R6: occupancy never exceeds the depth
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R10: a flush leaves the queue empty at the next edge
    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

    // R6: a full queue that is not popped keeps its level
    assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !flush) |=> full);
endmodule

// File: rtl/ssp_tx_shape.sv
module ssp_tx_shape
    import ssp_fifo_pkg::*;
(
    input  word_t      raw_word,
    input  size_code_t size_code,
    input  logic       byte_mode,
    output word_t      shaped_word
);
    word_t keep_mask;
    always_comb begin
        keep_mask   = byte_mode ? word_t'(16'h00FF) : size_mask(size_code);
        shaped_word = raw_word & keep_mask;
    end
endmodule

// File: rtl/ssp_rx_shape.sv
module ssp_rx_shape
    import ssp_fifo_pkg::*;
(
    input  word_t      frame_in,
    input  size_code_t size_code,
    output word_t      aligned_word
);
    always_comb begin
        aligned_word = frame_in & size_mask(size_code);
    end
endmodule

// File: rtl/ssp_data_fifo.sv
module ssp_data_fifo
    import ssp_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH+1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_en,
    input  logic          microwire,
    input  logic [3:0]    data_size,
    input  logic          wr_en,
    input  logic [15:0]   wr_data,
    input  logic          rd_en,
    output logic [15:0]   rd_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [15:0]   tx_data,
    input  logic          rx_valid,
    input  logic [15:0]   rx_data,
    output logic [LW-1:0] tx_level,
    output logic [LW-1:0] rx_level,
    output logic          tx_full,
    output logic          tx_empty,
    output logic          rx_full,
    output logic          rx_empty,
    output logic          tx_overflow,
    output logic          rx_overrun
);
    typedef struct packed {
        logic ovf;
        logic ovr;
    } flag_st_t;

    flag_st_t flg_d, flg_q;
    word_t    tx_head, rx_head, rx_aligned;
    logic     flush;

    assign flush = !port_en;

    ssp_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) tx_q_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(wr_en && port_en), .push_data(wr_data),
        .pop(tx_valid && tx_ready), .head(tx_head),
        .count(tx_level), .full(tx_full), .empty(tx_empty)
    );

    ssp_rx_shape rx_shape_i (
        .frame_in(rx_data), .size_code(data_size), .aligned_word(rx_aligned)
    );

    ssp_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) rx_q_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rx_valid && port_en), .push_data(rx_aligned),
        .pop(rd_en), .head(rx_head),
        .count(rx_level), .full(rx_full), .empty(rx_empty)
    );

    ssp_tx_shape tx_shape_i (
        .raw_word(tx_head), .size_code(data_size), .byte_mode(microwire),
        .shaped_word(tx_data)
    );

    always_comb begin
        flg_d = flg_q;
        if (flush) begin
            flg_d.ovf = 1'b0;
            flg_d.ovr = 1'b0;
        end else begin
            flg_d.ovf = wr_en && tx_full;
            flg_d.ovr = flg_q.ovr || (rx_valid && rx_full);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign tx_valid    = !tx_empty;
    assign rd_data     = rx_empty ? 16'h0000 : rx_head;
    assign tx_overflow = flg_q.ovf;
    assign rx_overrun  = flg_q.ovr;

    // R3: in normal format nothing above the frame length reaches the shifter
    assert_tx_trim_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !microwire) |-> ((tx_data & ~size_mask(data_size)) == 16'h0000));

    // R4: in Microwire format the upper byte is never sent
    assert_mw_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && microwire) |-> (tx_data[15:8] == 8'h00));

    // R7: an overflow pulse follows only a write into a full queue
    assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_overflow |-> $past(wr_en && tx_full && port_en));

    // R8: reading an empty receive queue with no arrival keeps it empty
    assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rx_empty && !rx_valid) |=> rx_empty);

    // R9: overrun stays set while the port stays enabled
    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && port_en) |=> rx_overrun);

    // R10: disabling the port empties both queues and clears the flags
    assert_disable_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (tx_empty && rx_empty && !rx_overrun && !tx_overflow));
endmodule

// File: tb/ssp_data_fifo_tb.sv
module ssp_data_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int LW         = $clog2(DEPTH+1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          port_en = 1'b0, microwire = 1'b0;
    logic [3:0]    data_size = 4'd7;
    logic          wr_en = 1'b0, rd_en = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0;
    logic [15:0]   wr_data = '0, rx_data = '0;
    logic [15:0]   rd_data, tx_data;
    logic          tx_valid, tx_full, tx_empty, rx_full, rx_empty, tx_overflow, rx_overrun;
    logic [LW-1:0] tx_level, rx_level;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] txq[$];
    logic [15:0] rxq[$];
    bit m_ovf = 0, m_ovr = 0, prev_dis = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssp_data_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .microwire(microwire),
        .data_size(data_size), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_level(tx_level), .rx_level(rx_level),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
        .tx_overflow(tx_overflow), .rx_overrun(rx_overrun)
    );

    function automatic logic [15:0] exp_mask(logic [3:0] code);
        int bits;
        bits = (code < 4'd3) ? 4 : int'(code) + 1;
        return 16'(((32'h1 << bits) - 1));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk("R6 tx_level", 32'(tx_level), 32'(txq.size()));
        chk("R6 rx_level", 32'(rx_level), 32'(rxq.size()));
        chk("R6 tx_full",  32'(tx_full),  32'(txq.size() == DEPTH));
        chk("R6 rx_full",  32'(rx_full),  32'(rxq.size() == DEPTH));
        chk("R6 tx_empty", 32'(tx_empty), 32'(txq.size() == 0));
        chk("R6 rx_empty", 32'(rx_empty), 32'(rxq.size() == 0));
        chk("R6 tx_valid", 32'(tx_valid), 32'(txq.size() != 0));
        if (txq.size() != 0) begin
            if (microwire)
                chk("R1/R4 microwire tx_data", 32'(tx_data), 32'(txq[0] & 16'h00FF));
            else
                chk("R1/R3 trimmed tx_data", 32'(tx_data), 32'(txq[0] & exp_mask(data_size)));
        end
        if (rxq.size() != 0)
            chk("R2/R5 rd_data", 32'(rd_data), 32'(rxq[0]));
        else
            chk("R8 empty rd_data", 32'(rd_data), 32'h0);
        chk("R7 tx_overflow", 32'(tx_overflow), 32'(m_ovf));
        chk("R9 rx_overrun",  32'(rx_overrun),  32'(m_ovr));
        if (prev_dis) begin
            chk("R10 tx flushed", 32'(tx_level), 32'h0);
            chk("R10 rx flushed", 32'(rx_level), 32'h0);
        end
    endtask

    // Model of one clock edge with the inputs currently driven
    task automatic model_step();
        bit tx_pop, tx_push, rx_pop, rx_push;
        if (!port_en) begin
            txq.delete();
            rxq.delete();
            m_ovf = 0;
            m_ovr = 0;
        end else begin
            m_ovf   = wr_en && (txq.size() == DEPTH);
            m_ovr   = m_ovr || (rx_valid && (rxq.size() == DEPTH));
            tx_pop  = tx_ready && (txq.size() != 0);
            tx_push = wr_en && (txq.size() != DEPTH);
            rx_pop  = rd_en && (rxq.size() != 0);
            rx_push = rx_valid && (rxq.size() != DEPTH);
            if (tx_pop) void'(txq.pop_front());
            if (tx_push) txq.push_back(wr_data);
            if (rx_pop) void'(rxq.pop_front());
            if (rx_push) rxq.push_back(rx_data & exp_mask(data_size));
        end
        prev_dis = !port_en;
    endtask

    function automatic bit chance(int pct);
        return ($urandom % 100) < pct;
    endfunction

    task automatic run_phase(int cycles, int p_wr, int p_rd, int p_txr, int p_rxv,
                             int p_dis, int mw_pct, int fixed_size);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            port_en   = !chance(p_dis);
            microwire = chance(mw_pct);
            data_size = (fixed_size < 0) ? 4'($urandom % 16) : 4'(fixed_size);
            wr_en     = chance(p_wr);
            wr_data   = 16'($urandom);
            rd_en     = chance(p_rd);
            tx_ready  = chance(p_txr);
            rx_valid  = chance(p_rxv);
            rx_data   = 16'($urandom);
            #1;
            check_outputs();
            model_step();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state (R10)
        chk("R10 reset tx_level", 32'(tx_level), 32'h0);
        chk("R10 reset rx_level", 32'(rx_level), 32'h0);
        chk("R10 reset rd_data",  32'(rd_data),  32'h0);
        chk("R10 reset flags",    32'({tx_overflow, rx_overrun}), 32'h0);
        // R8: read an empty receive queue
        run_phase(6, 0, 100, 0, 0, 0, 0, 7);
        // R1/R3: small size codes 0..2 act as 4 bits
        run_phase(20, 60, 0, 30, 40, 0, 0, 0);
        run_phase(20, 60, 50, 30, 40, 0, 0, 2);
        // R4: Microwire, full 16-bit receive size
        run_phase(200, 50, 50, 50, 50, 0, 100, 15);
        // R7: starve the shifter to overflow the transmit queue
        run_phase(40, 90, 0, 0, 0, 0, 0, -1);
        run_phase(30, 20, 0, 100, 0, 0, 0, -1);
        // R9: starve the reader to overrun the receive queue
        run_phase(40, 0, 0, 0, 90, 0, 0, -1);
        run_phase(20, 0, 10, 0, 50, 0, 0, -1);
        // R10: disable flush while both queues hold data
        run_phase(20, 80, 0, 0, 80, 0, 0, -1);
        run_phase(3, 80, 0, 0, 80, 100, 0, -1);
        // broad random mix
        run_phase(1500, 50, 45, 45, 50, 3, 30, -1);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule